// File: doc/BRIEF.md
# CAN Controller Sleep and Wake-Up Sequencer

This block decides when one CAN controller is asleep. Software raises a sleep-mode request bit. The block enters sleep only if the bus sample is recessive and no interrupt is pending at that moment. Otherwise the request is refused on the spot, and the refusal counts as a wake-up.

A sleeping controller wakes for one of two reasons:
- A dominant level is sampled on the bus. After this kind of wake-up, reception stays gated until the bus has shown a run of consecutive recessive bits.
- Software drops the sleep-mode request. After this kind of wake-up, reception is permitted again straight away.

Every wake-up raises a sticky wake-up interrupt flag, but only when the wake-up interrupt enable is set. Software clears the flag with a one-cycle clear pulse. The bus sample and the bit-time strobe are produced by the bit-timing logic that sits outside this block.

Top module: `can_slumber_ctl`

## Requirements
- R1: After reset, `asleep` is 0, `wake_irq` is 0 and `rx_permit` is 1.
- R2: Sleep is entered on a 0-to-1 change of `sleep_req` while `bus_dom` is 0 and `irq_pend` is 0. One cycle later `asleep` is 1 and `rx_permit` is 0. Holding `sleep_req` at 1 afterwards never re-enters sleep.
- R3: On a 0-to-1 change of `sleep_req` while `bus_dom` is 1 or `irq_pend` is 1, `asleep` stays 0. This refusal is a wake-up event.
- R4: While asleep, a cycle with `bit_stb`=1 and `bus_dom`=1 (1 means dominant) is a wake-up event. One cycle later `asleep` is 0 and `rx_permit` is 0. If `sleep_req` is 0 in that same cycle, this bus wake-up takes precedence.
- R5: While asleep, `sleep_req` at 0 with no bus wake-up in that cycle is a wake-up event. One cycle later `asleep` is 0 and `rx_permit` is 1.
- R6: After a bus wake-up, `rx_permit` returns to 1 one cycle after the strobe that samples the IDLE_BITS-th consecutive recessive bit. IDLE_BITS defaults to 11. A strobe that samples dominant restarts the run.
- R7: A wake-up event sets `wake_irq` one cycle later when `wake_en` is 1. When `wake_en` is 0, `wake_irq` is left unchanged.
- R8: A `wake_clr` pulse clears `wake_irq` one cycle later, unless a wake-up event with `wake_en` at 1 occurs in the same cycle. In that case the flag is set.
- R9: Cycles with `bit_stb` at 0 neither wake a sleeping block nor advance or restart the recessive-run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Software sleep-mode request bit (level) |
| bus_dom | input | 1 | Sampled bus level, 1 = dominant |
| bit_stb | input | 1 | One-cycle strobe marking a valid bus sample |
| irq_pend | input | 1 | Any controller interrupt pending |
| wake_en | input | 1 | Wake-up interrupt enable |
| wake_clr | input | 1 | Write-one-to-clear pulse for the wake-up flag |
| asleep | output | 1 | Controller is in sleep mode |
| wake_irq | output | 1 | Sticky wake-up interrupt flag |
| rx_permit | output | 1 | Reception is allowed |

## Verification
Directed sequences cover the following cases:
- A clean sleep entry, and sleep refused by a dominant bus or by a pending interrupt. These show how the entry check and the refusal-as-wake-up path differ.
- A dominant level with no strobe, compared with a strobed dominant level. This shows that only strobed samples count.
- A recessive run that is broken by one dominant strobe and then completed. This shows that the counter restarts rather than pauses.
- A software wake-up with the enable off. This separates the ungated software path from the gated bus path, and the flag enable from the wake-up itself.

A long random phase then mixes request toggles, sparse dominant samples, strobes, pending interrupts and clear pulses. Every cycle is compared with a bench-side model built from the requirements. This exposes ordering cases such as a bus wake-up and a software wake-up arriving in the same cycle, or a clear and a set arriving together.

// File: rtl/can_slumber_pkg.sv
package can_slumber_pkg;
   typedef enum logic [1:0] {
      SLM_AWAKE  = 2'd0,
      SLM_ASLEEP = 2'd1,
      SLM_HOLD   = 2'd2
   } slm_state_e;
endpackage

// File: rtl/can_slumber_fsm.sv
module can_slumber_fsm
   import can_slumber_pkg::*;
#(
   parameter bit STB_QUALIFY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       bus_dom,
   input  logic       bit_stb,
   input  logic       irq_pend,
   input  logic       idle_done,
   output slm_state_e state,
   output logic       wake_evt,
   output logic       hold_start
);
   logic       req_q;
   logic       req_rise;
   logic       bus_hit;
   slm_state_e nxt;

   generate
      if (STB_QUALIFY) begin : g_stb_wake
         assign bus_hit = bus_dom & bit_stb;
      end else begin : g_level_wake
         assign bus_hit = bus_dom;
      end
   endgenerate

   assign req_rise = sleep_req & ~req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= sleep_req;
   end

   always_comb begin
      nxt        = state;
      wake_evt   = 1'b0;
      hold_start = 1'b0;
      unique case (state)
         SLM_AWAKE: begin
            if (req_rise) begin
               if (bus_dom || irq_pend) wake_evt = 1'b1;
               else                     nxt      = SLM_ASLEEP;
            end
         end
         SLM_ASLEEP: begin
            if (bus_hit) begin
               nxt        = SLM_HOLD;
               wake_evt   = 1'b1;
               hold_start = 1'b1;
            end else if (!sleep_req) begin
               nxt      = SLM_AWAKE;
               wake_evt = 1'b1;
            end
         end
         SLM_HOLD: begin
            if (idle_done) nxt = SLM_AWAKE;
         end
         default: nxt = SLM_AWAKE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SLM_AWAKE;
      else        state <= nxt;
   end

   AST_REFUSE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SLM_AWAKE && req_rise && (bus_dom || irq_pend)) |=> state != SLM_ASLEEP) else $error("refuse"); // R3
   AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SLM_AWAKE && req_rise && !bus_dom && !irq_pend) |=> state == SLM_ASLEEP) else $error("enter"); // R2
   AST_BUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SLM_ASLEEP && bus_dom && bit_stb) |=> state == SLM_HOLD) else $error("bus wake"); // R4
   AST_SW_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SLM_ASLEEP && !sleep_req && !bus_dom) |=> state == SLM_AWAKE) else $error("sw wake"); // R5
endmodule

// File: rtl/can_slumber_idle.sv
module can_slumber_idle #(
   parameter int IDLE_BITS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic active,
   input  logic bit_stb,
   input  logic bus_dom,
   output logic idle_done
);
   localparam int CNT_W = (IDLE_BITS < 2) ? 1 : $clog2(IDLE_BITS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

   generate
      if (IDLE_BITS < 1) begin : g_bad_len
         $error("IDLE_BITS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] run_cnt;

   assign idle_done = active & bit_stb & ~bus_dom & (run_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    run_cnt <= '0;
      else if (clear)                run_cnt <= '0;
      else if (active && bit_stb) begin
         if (bus_dom || run_cnt == LAST) run_cnt <= '0;
         else                            run_cnt <= run_cnt + 1'b1;
      end
   end

   AST_CNT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_stb && !clear) |=> $stable(run_cnt)) else $error("count moved"); // R9
   AST_CNT_DOM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (active && bit_stb && bus_dom) |=> run_cnt == '0) else $error("restart"); // R6
endmodule

// File: rtl/can_slumber_flag.sv
module can_slumber_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic enable,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag <= 1'b0;
      else if (set_evt && enable) flag <= 1'b1;
      else if (clr)              flag <= 1'b0;
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_evt && enable) |=> flag) else $error("flag set"); // R7
   AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(set_evt && enable)) |=> !flag) else $error("flag clr"); // R8
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(set_evt && enable)) |=> $stable(flag)) else $error("flag hold"); // R7
endmodule

// File: rtl/can_slumber_ctl.sv
module can_slumber_ctl
   import can_slumber_pkg::*;
#(
   parameter int IDLE_BITS   = 11,
   parameter bit STB_QUALIFY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic bus_dom,
   input  logic bit_stb,
   input  logic irq_pend,
   input  logic wake_en,
   input  logic wake_clr,
   output logic asleep,
   output logic wake_irq,
   output logic rx_permit
);
   slm_state_e state;
   logic       wake_evt;
   logic       hold_start;
   logic       idle_done;

   can_slumber_fsm #(.STB_QUALIFY(STB_QUALIFY)) fsm_i (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .bus_dom(bus_dom),
      .bit_stb(bit_stb), .irq_pend(irq_pend), .idle_done(idle_done),
      .state(state), .wake_evt(wake_evt), .hold_start(hold_start)
   );

   can_slumber_idle #(.IDLE_BITS(IDLE_BITS)) idle_i (
      .clk(clk), .rst_n(rst_n), .clear(hold_start),
      .active(state == SLM_HOLD), .bit_stb(bit_stb), .bus_dom(bus_dom),
      .idle_done(idle_done)
   );

   can_slumber_flag flag_i (
      .clk(clk), .rst_n(rst_n), .set_evt(wake_evt), .enable(wake_en),
      .clr(wake_clr), .flag(wake_irq)
   );

   assign asleep    = (state == SLM_ASLEEP);
   assign rx_permit = (state == SLM_AWAKE);

   AST_SLEEP_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep) |-> $past(sleep_req) && !$past(irq_pend)) else $error("bad entry"); // R2
   AST_BUS_WAKE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && bus_dom && bit_stb) |=> !rx_permit && !asleep) else $error("gate"); // R4
endmodule

// File: tb/can_slumber_ctl_tb_top.sv
module can_slumber_ctl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 0, bus_dom = 0, bit_stb = 0, irq_pend = 0, wake_en = 0, wake_clr = 0;
   logic asleep, wake_irq, rx_permit;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int m_st = 0;
   int m_cnt = 0;
   bit m_flag = 0;
   bit m_req_q = 0;

   always #4 clk = ~clk;

   can_slumber_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .bus_dom(bus_dom),
      .bit_stb(bit_stb), .irq_pend(irq_pend), .wake_en(wake_en),
      .wake_clr(wake_clr), .asleep(asleep), .wake_irq(wake_irq),
      .rx_permit(rx_permit)
   );

   function automatic bit exp_asleep(int st);
      return st == 1;
   endfunction

   function automatic bit exp_rx(int st);
      return st == 0;
   endfunction

   task automatic model_step();
      bit rise;
      bit wake;
      rise = sleep_req && !m_req_q;
      m_req_q = sleep_req;
      wake = 0;
      case (m_st)
         0: if (rise) begin
               if (bus_dom || irq_pend) wake = 1;
               else m_st = 1;
            end
         1: if (bit_stb && bus_dom) begin
               m_st = 2; m_cnt = 0; wake = 1;
            end else if (!sleep_req) begin
               m_st = 0; wake = 1;
            end
         default: if (bit_stb) begin
               if (bus_dom) m_cnt = 0;
               else if (m_cnt == 10) begin m_st = 0; m_cnt = 0; end
               else m_cnt++;
            end
      endcase
      if (wake && wake_en) m_flag = 1;
      else if (wake_clr) m_flag = 0;
   endtask

   task automatic compare(input string tag);
      checks++;
      if (asleep !== exp_asleep(m_st) || rx_permit !== exp_rx(m_st) || wake_irq !== m_flag) begin
         failures++;
         $display("FAIL %s: asleep/rx/irq actual=%b%b%b expected=%b%b%b", tag,
                  asleep, rx_permit, wake_irq, exp_asleep(m_st), exp_rx(m_st), m_flag);
      end
   endtask

   task automatic cyc(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1 reset");
      wake_en = 1;
      sleep_req = 1;
      cyc("R2 enter");
      cyc("R2 hold high no reentry");
      bus_dom = 1;
      cyc("R9 dominant without strobe");
      bit_stb = 1;
      cyc("R4 bus wake");
      bus_dom = 0;
      for (int i = 0; i < 5; i++) cyc("R6 partial run");
      bus_dom = 1;
      cyc("R6 dominant restart");
      bus_dom = 0;
      for (int i = 0; i < 10; i++) cyc("R6 still blocked");
      bit_stb = 0;
      cyc("R9 no strobe no advance");
      bit_stb = 1;
      cyc("R6 eleventh recessive");
      bit_stb = 0;
      wake_clr = 1;
      cyc("R8 clear");
      wake_clr = 0;
      sleep_req = 0;
      cyc("R3 prep");
      irq_pend = 1; sleep_req = 1;
      cyc("R3 refused irq");
      irq_pend = 0; sleep_req = 0; wake_clr = 1;
      cyc("R8 clear again");
      wake_clr = 0; bus_dom = 1; sleep_req = 1;
      cyc("R3 refused bus");
      bus_dom = 0; sleep_req = 0; wake_clr = 1;
      cyc("R8 clear 3");
      wake_clr = 0; sleep_req = 1;
      cyc("R2 enter again");
      wake_en = 0; sleep_req = 0;
      cyc("R5 software wake");
      cyc("R7 enable off keeps flag");
      sleep_req = 1; wake_en = 1;
      cyc("R2 enter 3");
      sleep_req = 0; bus_dom = 1; bit_stb = 1;
      cyc("R4 bus precedence");
      wake_clr = 1; bus_dom = 0;
      cyc("R8 set-clear");
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 7) == 0) sleep_req = ~sleep_req;
         bus_dom  = ($urandom_range(0, 9) == 0);
         bit_stb  = ($urandom_range(0, 2) == 0);
         irq_pend = ($urandom_range(0, 5) == 0);
         wake_en  = ($urandom_range(0, 3) != 0);
         wake_clr = ($urandom_range(0, 6) == 0);
         cyc("R2 R3 R4 R5 R6 R7 R8 R9 random");
      end
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule